// File: doc/BRIEF.md
# Tile Error Propagation and Fault Locator

This block watches a rectangular array of physical tiles, each of which carries one or more local self-checkers. Every tile cell folds its checkers into a single tile error flag. It registers that flag and passes error status to its right-hand and lower neighbours through a horizontal and a vertical port. The chain ends give an external reconfiguration controller a per-row and per-column summary of which parts of the array are reporting errors.

Data moves through the array in a fixed order: left to right along a row, then on to the next row down. An error raised in one tile can therefore reappear in tiles further along that order. The central locator picks the flagged tile that comes first in flow order and reports it as the faulty physical tile. That result is held until the controller clears it. Every flag and every propagated status bit travels on two independent rails. A disagreement between the rails anywhere in the array raises a separate error-network alarm and marks the location result as untrustworthy.

Top module: `tile_fault_locator`

## Requirements
- R1: After reset, fault_valid, network_fault, row_err and col_err are all low.
- R2: A tile is flagged when any of its CHK checker inputs is high. Checker k of the tile in row r, column c is input bit ((r*COLS)+c)*CHK+k. The flag is captured at the next clock edge and is visible on row_err/col_err right after that edge.
- R3: row_err[r] is high exactly when some tile in row r is flagged, and col_err[c] is high exactly when some tile in column c is flagged.
- R4: The locator reports the flagged tile with the lowest flow index r*COLS+c on fault_row/fault_col. fault_valid rises at the second clock edge after the checker input was applied.
- R5: While a result is held, later checker errors change neither fault_valid nor fault_row/fault_col.
- R6: A fault_clear pulse drops the held result and network_fault at the next edge. Clear wins over a new capture in the same cycle.
- R7: If the two rails of any tile flag or any propagated status bit disagree, network_fault rises at the next edge and stays high until cleared. While it is high, fault_valid reads low.
- R8: A location is not captured in a cycle where the rails disagree. rail_upset bit r*COLS+c inverts the shadow rail of that tile's flag, which models a defect in the error network.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_err | input | ROWS*COLS*CHK | Local checker outputs, CHK per tile, tile-major in flow order |
| rail_upset | input | ROWS*COLS | Per-tile inversion of the shadow flag rail (network defect model) |
| fault_clear | input | 1 | Releases the held location and the network alarm |
| row_err | output | ROWS | Per-row error summary from the horizontal chains |
| col_err | output | COLS | Per-column error summary from the vertical chains |
| fault_valid | output | 1 | Held location is present and trustworthy |
| fault_row | output | max(1,clog2(ROWS)) | Row of the located tile |
| fault_col | output | max(1,clog2(COLS)) | Column of the located tile |
| network_fault | output | 1 | Rail disagreement seen in the error network |

## Verification
The bench builds the array with 3 rows, 5 columns and 3 checkers per tile. The uneven grid means the row and column arithmetic cannot pass by symmetry. The five-tile rows let a downstream tile sit in a lower column than the true upstream one, so a wrong priority order shows up as a wrong location. Three checkers per tile let any single checker bit in any position flag its tile. Random sparse error patterns are mixed with a few directed cases: only the first tile, only the last tile, every tile, and an error-network defect with and without real errors.

// File: rtl/tfl_pkg.sv
// Shared types for the tile error network.
// Assumes: one rail pair per propagated error bit; both rails active-high.
package tfl_pkg;

    // Dual-rail error bit: a = main rail, b = shadow rail.
    typedef struct packed {
        logic a;
        logic b;
    } rail_t;

    // Width helper that never returns zero.
    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tfl_cell.sv
// One tile cell: ORs the local checker outputs into one tile flag and
// registers it on both rails. It extends the horizontal and vertical
// status chains with that flag and reports any rail disagreement it sees.
// Assumes: synchronous active-low reset; upset only touches the shadow rail.
module tfl_cell
    import tfl_pkg::*;
#(
    parameter int CHK = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CHK-1:0] chk_in,
    input  logic           upset,
    input  rail_t          h_in,
    input  rail_t          v_in,
    output rail_t          h_out,
    output rail_t          v_out,
    output logic           flag_main,
    output logic           rail_mis
);

    logic  merged;
    rail_t flag_q;

    // Merge all local checkers into one tile error indication.
    always_comb merged = |chk_in;

    // Register the tile flag on both rails once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q.a <= merged;
            flag_q.b <= merged ^ upset;
        end
    end

    // Extend both rails of the horizontal and vertical chains.
    always_comb begin
        h_out.a = h_in.a | flag_q.a;
        h_out.b = h_in.b | flag_q.b;
        v_out.a = v_in.a | flag_q.a;
        v_out.b = v_in.b | flag_q.b;
    end

    // Compare rails of every bit this cell drives.
    always_comb begin
        flag_main = flag_q.a;
        rail_mis  = (flag_q.a ^ flag_q.b) | (h_out.a ^ h_out.b) | (v_out.a ^ v_out.b);
    end

    // R2
    tile_flag_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|chk_in)) |-> flag_main);

endmodule

// File: rtl/tfl_grid.sv
// ROWS x COLS array of tile cells. Horizontal chains run along each row
// from column 0; vertical chains run down each column from row 0. The
// main rail of the last cell of each chain gives the row or column summary.
// Assumes: tile index r*COLS+c is the data-flow order.
module tfl_grid
    import tfl_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int CHK  = 2,
    localparam int NT  = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT*CHK-1:0] chk_err,
    input  logic [NT-1:0]     rail_upset,
    output logic [NT-1:0]     tile_flag,
    output logic [ROWS-1:0]   row_err,
    output logic [COLS-1:0]   col_err,
    output logic              net_mis
);

    rail_t       hw [ROWS][COLS+1];
    rail_t       vw [ROWS+1][COLS];
    logic [NT-1:0] mis_vec;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign hw[r][0] = '0;
        assign row_err[r] = hw[r][COLS].a;
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            tfl_cell #(.CHK(CHK)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .chk_in    (chk_err[IDX*CHK +: CHK]),
                .upset     (rail_upset[IDX]),
                .h_in      (hw[r][c]),
                .v_in      (vw[r][c]),
                .h_out     (hw[r][c+1]),
                .v_out     (vw[r+1][c]),
                .flag_main (tile_flag[IDX]),
                .rail_mis  (mis_vec[IDX])
            );
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_colend
        assign vw[0][c]   = '0;
        assign col_err[c] = vw[ROWS][c].a;
    end

    // Any cell reporting a rail disagreement flags the network.
    always_comb net_mis = |mis_vec;

endmodule

// File: rtl/tfl_locator.sv
// Picks the flagged tile earliest in flow order, holds it until cleared,
// and keeps a sticky alarm for error-network rail disagreement.
// Assumes: tile_flag is registered; fault_clear is a one-cycle pulse.
module tfl_locator
    import tfl_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int NT  = ROWS * COLS,
    localparam int RW  = safe_clog2(ROWS),
    localparam int CW  = safe_clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] tile_flag,
    input  logic          net_mis,
    input  logic          fault_clear,
    output logic          fault_valid,
    output logic [RW-1:0] fault_row,
    output logic [CW-1:0] fault_col,
    output logic          network_fault
);

    logic          any_flag;
    logic [RW-1:0] pick_row;
    logic [CW-1:0] pick_col;
    logic          held;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic          net_q;

    // Priority search: lowest flow index wins, scanning from the end.
    always_comb begin
        any_flag = 1'b0;
        pick_row = '0;
        pick_col = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            for (int c = COLS - 1; c >= 0; c--) begin
                if (tile_flag[r*COLS + c]) begin
                    any_flag = 1'b1;
                    pick_row = RW'(r);
                    pick_col = CW'(c);
                end
            end
        end
    end

    // Hold the first trusted location until clear; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= 1'b0;
            row_q <= '0;
            col_q <= '0;
        end else if (fault_clear) begin
            held <= 1'b0;
        end else if (!held && any_flag && !net_mis) begin
            held  <= 1'b1;
            row_q <= pick_row;
            col_q <= pick_col;
        end
    end

    // Sticky error-network alarm, released only by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           net_q <= 1'b0;
        else if (fault_clear) net_q <= 1'b0;
        else if (net_mis)     net_q <= 1'b1;
    end

    // Present the result, invalidated while the network is suspect.
    always_comb begin
        fault_valid   = held & ~net_q;
        fault_row     = row_q;
        fault_col     = col_q;
        network_fault = net_q;
    end

    // R4
    location_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_valid) |-> $past(any_flag));

    // R5
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !fault_clear) |=> (held && $stable(row_q) && $stable(col_q)));

    // R6
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_clear |=> (!held && !network_fault));

    // R7
    net_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_mis && !fault_clear) |=> network_fault);

    // R8
    no_capture_on_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_mis && !held) |=> !held);

endmodule

// File: rtl/tile_fault_locator.sv
// Top level: tile error grid plus fault locator.
// Assumes: synchronous active-low reset; flow order is row-major.
module tile_fault_locator
    import tfl_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int CHK  = 2,
    localparam int NT  = ROWS * COLS,
    localparam int RW  = safe_clog2(ROWS),
    localparam int CW  = safe_clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT*CHK-1:0] chk_err,
    input  logic [NT-1:0]     rail_upset,
    input  logic              fault_clear,
    output logic [ROWS-1:0]   row_err,
    output logic [COLS-1:0]   col_err,
    output logic              fault_valid,
    output logic [RW-1:0]     fault_row,
    output logic [CW-1:0]     fault_col,
    output logic              network_fault
);

    logic [NT-1:0] tile_flag;
    logic          net_mis;

    tfl_grid #(.ROWS(ROWS), .COLS(COLS), .CHK(CHK)) u_grid (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_err    (chk_err),
        .rail_upset (rail_upset),
        .tile_flag  (tile_flag),
        .row_err    (row_err),
        .col_err    (col_err),
        .net_mis    (net_mis)
    );

    tfl_locator #(.ROWS(ROWS), .COLS(COLS)) u_loc (
        .clk           (clk),
        .rst_n         (rst_n),
        .tile_flag     (tile_flag),
        .net_mis       (net_mis),
        .fault_clear   (fault_clear),
        .fault_valid   (fault_valid),
        .fault_row     (fault_row),
        .fault_col     (fault_col),
        .network_fault (network_fault)
    );

endmodule

// File: tb/tb_tile_fault_locator.sv
module tb_tile_fault_locator;

    localparam int ROWS = 3;
    localparam int COLS = 5;
    localparam int CHK  = 3;
    localparam int NT   = ROWS * COLS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NT*CHK-1:0] chk_err = '0;
    logic [NT-1:0]     rail_upset = '0;
    logic              fault_clear = 1'b0;
    logic [ROWS-1:0]   row_err;
    logic [COLS-1:0]   col_err;
    logic              fault_valid;
    logic [1:0]        fault_row;
    logic [2:0]        fault_col;
    logic              network_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    tile_fault_locator #(.ROWS(ROWS), .COLS(COLS), .CHK(CHK)) dut (
        .clk(clk), .rst_n(rst_n), .chk_err(chk_err), .rail_upset(rail_upset),
        .fault_clear(fault_clear), .row_err(row_err), .col_err(col_err),
        .fault_valid(fault_valid), .fault_row(fault_row), .fault_col(fault_col),
        .network_fault(network_fault)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Lowest flagged tile index, -1 when no tile is flagged (R2, R4).
    function automatic int first_tile(input logic [NT*CHK-1:0] p);
        for (int i = 0; i < NT; i++)
            if (|p[i*CHK +: CHK]) return i;
        return -1;
    endfunction

    function automatic int exp_rows(input logic [NT*CHK-1:0] p);
        int m = 0;
        for (int i = 0; i < NT; i++)
            if (|p[i*CHK +: CHK]) m |= (1 << (i / COLS));
        return m;
    endfunction

    function automatic int exp_cols(input logic [NT*CHK-1:0] p);
        int m = 0;
        for (int i = 0; i < NT; i++)
            if (|p[i*CHK +: CHK]) m |= (1 << (i % COLS));
        return m;
    endfunction

    // One full vector: apply, check summaries, check location, optional hold probe, clear.
    task automatic run_vec(input logic [NT*CHK-1:0] p, input logic [NT-1:0] up, input bit probe);
        int idx;
        bit valid_exp;
        idx = first_tile(p);
        valid_exp = (idx >= 0) && (up == '0);
        chk_err = p; rail_upset = up;
        @(negedge clk);
        check("R2/R3 row_err", int'(row_err), exp_rows(p));
        check("R2/R3 col_err", int'(col_err), exp_cols(p));
        chk_err = '0; rail_upset = '0;
        @(negedge clk);
        check("R4/R7/R8 fault_valid", int'(fault_valid), int'(valid_exp));
        check("R7 network_fault", int'(network_fault), int'(up != '0));
        if (valid_exp) begin
            check("R4 fault_row", int'(fault_row), idx / COLS);
            check("R4 fault_col", int'(fault_col), idx % COLS);
            if (probe) begin
                chk_err = '0;
                chk_err[0] = 1'b1;               // a lower-index tile errors later
                @(negedge clk);
                chk_err = '0;
                @(negedge clk);
                check("R5 held valid", int'(fault_valid), 1);
                check("R5 held row", int'(fault_row), idx / COLS);
                check("R5 held col", int'(fault_col), idx % COLS);
            end
        end
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        check("R6 valid after clear", int'(fault_valid), 0);
        check("R6 net after clear", int'(network_fault), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [NT*CHK-1:0] p;
        logic [NT-1:0]     up;
        int s;
        s = $urandom(32'h1ce5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 fault_valid", int'(fault_valid), 0);
        check("R1 network_fault", int'(network_fault), 0);
        check("R1 row_err", int'(row_err), 0);
        check("R1 col_err", int'(col_err), 0);

        // Directed: only first tile, checker 2 (R2 bit position)
        p = '0; p[2] = 1'b1;                    run_vec(p, '0, 1'b0);
        // Directed: only last tile, checker 0
        p = '0; p[(NT-1)*CHK] = 1'b1;           run_vec(p, '0, 1'b1);
        // Directed: every tile flagged -> tile 0 wins
        p = '1;                                  run_vec(p, '0, 1'b0);
        // Directed: downstream tile (1,0) plus upstream tile (0,4): R4 picks (0,4)
        p = '0; p[(1*COLS+0)*CHK] = 1'b1; p[(0*COLS+4)*CHK+1] = 1'b1;
        run_vec(p, '0, 1'b1);
        // Directed: network defect with no real error (R7)
        p = '0; up = '0; up[7] = 1'b1;          run_vec(p, up, 1'b0);
        // Directed: network defect with real error blocks capture (R8)
        p = '0; p[5*CHK] = 1'b1; up = '0; up[12] = 1'b1;
        run_vec(p, up, 1'b0);

        // Constrained random sparse patterns
        for (int v = 0; v < 400; v++) begin
            p = '0; up = '0;
            for (int t = 0; t < NT; t++)
                if (($urandom % 5) == 0)
                    p[t*CHK +: CHK] = CHK'(($urandom % 7) + 1);
            if (($urandom % 6) == 0) up[$urandom % NT] = 1'b1;
            run_vec(p, up, (($urandom % 3) == 0));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule